// File: doc/BRIEF.md
# Dual-port word memory with address-contention arbitration

This block is a synchronous, true dual-port memory with a left and a right port. Each port has its own chip select, write strobe, output enable, access-exclusion input, two byte-lane selects, address, write data and read data. Both ports run at the same time and reach any word, so two agents such as two processors can share a buffer without stalling each other.

When both ports access the same word in the same cycle, an arbiter grants the port whose access started earlier. The other port sees a busy flag, and its access is suppressed. A mode input picks the role of the block in a cascade. As master it drives the busy flags out. As slave it takes busy flags in from an external master and holds off the writes of the flagged port. A held-off write lands in the cycle the flag drops if the port is still requesting. The word count is set by the `ADDR_W` parameter: 13 gives 8192 words, and the default keeps elaboration small.

Top module: `dpram_arb`

## Requirements
- R1: The memory holds 2**ADDR_W words of 16 bits. A word written at any address, including address 0 and the top address, reads back unchanged from either port.
- R2: Lane select bit 1 covers data bits 15:8 and bit 0 covers bits 7:0. A write changes only the selected lanes of the word. A read loads only the selected lanes of the port's read register, and the other lanes keep their value.
- R3: A port accesses memory only when its chip select is 1, at least one lane select is 1 and its exclusion input is 0. Otherwise nothing is written and its read register holds.
- R4: In master mode a port's busy output is 1 in the same cycle if and only if both ports access memory at the same address and that port lost arbitration. The two busy outputs are never 1 together, and they clear as soon as the addresses differ or either access ends.
- R5: A port's access starts in the first cycle of an unbroken run of accesses to one address. At a match, the port with the earlier start wins. Equal starts grant the left port. The winner keeps the grant while both runs continue.
- R6: In master mode the busy port's write is dropped, not queued, and its read is not performed, so its read register keeps its value.
- R7: In slave mode both busy outputs are 0. A busy input of 1 blocks that port's writes, while its reads proceed. A blocked write still requested when the busy input returns to 0 is written in that cycle. In master mode the busy inputs have no effect.
- R8: Read data appears on the read-data output after the rising edge that samples the read request. The output is 0 in any cycle where the port's chip select or output enable is 0.
- R9: Accesses to different addresses proceed on both ports in the same cycle. In slave mode with no busy input set, a read of a word the other port writes in the same cycle returns the old contents.
- R10: After reset both read registers are 0 and both busy outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1: busy flags are inputs; 0: busy flags are outputs |
| l_cs | input | 1 | Left chip select |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_excl | input | 1 | Left access exclusion; 1 blocks memory access |
| l_ben | input | 2 | Left lane selects, bit 1 upper byte, bit 0 lower byte |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_busy_i | input | 1 | Left busy from an external master (slave mode) |
| l_busy_o | output | 1 | Left lost arbitration (master mode) |
| l_rdata | output | 16 | Left read data |
| r_cs | input | 1 | Right chip select |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output enable |
| r_excl | input | 1 | Right access exclusion; 1 blocks memory access |
| r_ben | input | 2 | Right lane selects, bit 1 upper byte, bit 0 lower byte |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_busy_i | input | 1 | Right busy from an external master (slave mode) |
| r_busy_o | output | 1 | Right lost arbitration (master mode) |
| r_rdata | output | 16 | Right read data |

## Verification
The arbiter keeps a little history: the previous request, address and winner of each port. A corrupted history shows up at the next contended cycle as a busy flag on the wrong port or a winner that flips mid-run, and the bench compares both busy flags against its model in every cycle, before the clock edge. A wrong lane mask or a write that should have been blocked leaves a bad word in memory. That shows up only when the word is next read, one edge after the read request, so the bench rereads contended and blocked addresses right away. It also confines random traffic to a few addresses so that every stale word is read again within a few cycles.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_mode,
  input  logic              l_cs,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_excl,
  input  logic [DATA_W/8-1:0] l_ben,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_cs,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_excl,
  input  logic [DATA_W/8-1:0] r_ben,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] l_q, r_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic              l_req_q, r_req_q, win_r_q;

  wire l_req  = l_cs & (|l_ben) & ~l_excl;
  wire r_req  = r_cs & (|r_ben) & ~r_excl;
  wire hit    = l_req & r_req & (l_addr == r_addr);
  wire l_cont = l_req_q & (l_addr_q == l_addr);
  wire r_cont = r_req_q & (r_addr_q == r_addr);
  wire win_r  = (l_cont & r_cont) ? win_r_q : (r_cont & ~l_cont);

  assign l_busy_o = ~slave_mode & hit & win_r;
  assign r_busy_o = ~slave_mode & hit & ~win_r;

  wire l_blk = slave_mode ? l_busy_i : l_busy_o;
  wire r_blk = slave_mode ? r_busy_i : r_busy_o;
  wire l_wr  = l_req & l_we & ~l_blk;
  wire r_wr  = r_req & r_we & ~r_blk;
  wire l_rd  = l_req & ~l_we & ~l_busy_o;
  wire r_rd  = r_req & ~r_we & ~r_busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_req_q  <= 1'b0;
      r_req_q  <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      win_r_q  <= 1'b0;
    end else begin
      l_req_q  <= l_req;
      r_req_q  <= r_req;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      win_r_q  <= win_r;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (l_wr && l_ben[b]) mem[l_addr][b*8 +: 8] <= l_wdata[b*8 +: 8];
      if (r_wr && r_ben[b]) mem[r_addr][b*8 +: 8] <= r_wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= '0;
      r_q <= '0;
    end else begin
      for (int b = 0; b < LANES; b++) begin
        if (l_rd && l_ben[b]) l_q[b*8 +: 8] <= mem[l_addr][b*8 +: 8];
        if (r_rd && r_ben[b]) r_q[b*8 +: 8] <= mem[r_addr][b*8 +: 8];
      end
    end
  end

  assign l_rdata = (l_cs & l_oe) ? l_q : '0;
  assign r_rdata = (r_cs & r_oe) ? r_q : '0;
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_mode,
  input logic              l_cs,
  input logic              l_oe,
  input logic              l_excl,
  input logic [DATA_W/8-1:0] l_ben,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_cs,
  input logic              r_oe,
  input logic              r_excl,
  input logic [DATA_W/8-1:0] r_ben,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_o,
  input logic              r_busy_o,
  input logic [DATA_W-1:0] l_rdata,
  input logic [DATA_W-1:0] r_rdata
);
  wire lreq = l_cs && (l_ben != '0) && !l_excl;
  wire rreq = r_cs && (r_ben != '0) && !r_excl;
  wire same = lreq && rreq && (l_addr == r_addr);

  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_o && r_busy_o));
  a_r4_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_o || r_busy_o) |-> (same && !slave_mode));
  a_r4_match_flags_one: assert property (@(posedge clk) disable iff (!rst_n)
    (same && !slave_mode) |-> (l_busy_o || r_busy_o));
  a_r5_left_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && same && $stable(l_addr) && $stable(r_addr) && $past(l_busy_o)) |-> l_busy_o);
  a_r5_right_loss_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && same && $stable(l_addr) && $stable(r_addr) && $past(r_busy_o)) |-> r_busy_o);
  a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!l_busy_o && !r_busy_o));
  a_r8_left_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_cs && l_oe) |-> (l_rdata == '0));
  a_r8_right_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_cs && r_oe) |-> (r_rdata == '0));
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
  .l_cs(l_cs), .l_oe(l_oe), .l_excl(l_excl), .l_ben(l_ben), .l_addr(l_addr),
  .r_cs(r_cs), .r_oe(r_oe), .r_excl(r_excl), .r_ben(r_ben), .r_addr(r_addr),
  .l_busy_o(l_busy_o), .r_busy_o(r_busy_o), .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/tb_dpram_arb.sv
module tb_dpram_arb;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic clk = 0, rst_n = 0, slave_mode = 0;
  logic l_cs = 0, l_we = 0, l_oe = 0, l_excl = 0, l_busy_i = 0;
  logic r_cs = 0, r_we = 0, r_oe = 0, r_excl = 0, r_busy_i = 0;
  logic [1:0] l_ben = 0, r_ben = 0;
  logic [AW-1:0] l_addr = 0, r_addr = 0;
  logic [15:0] l_wdata = 0, r_wdata = 0;
  logic l_busy_o, r_busy_o;
  logic [15:0] l_rdata, r_rdata;

  always #4 clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .DATA_W(16)) dut (.*);

  logic [15:0] m [DEPTH];
  logic [15:0] ml_q = 0, mr_q = 0;
  logic lp_req = 0, rp_req = 0, eb_l = 0, eb_r = 0;
  logic [AW-1:0] lp_addr = 0, rp_addr = 0;
  int cyc = 0, lstart = 0, rstart = 0, ls = 0, rs = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit lreq_f(); return l_cs && l_ben != 0 && !l_excl; endfunction
  function automatic bit rreq_f(); return r_cs && r_ben != 0 && !r_excl; endfunction

  task automatic eval_busy();
    bit lr, rr, hit;
    lr = lreq_f(); rr = rreq_f();
    ls = (lr && (!lp_req || l_addr != lp_addr)) ? cyc : lstart;
    rs = (rr && (!rp_req || r_addr != rp_addr)) ? cyc : rstart;
    hit = lr && rr && (l_addr == r_addr);
    eb_l = !slave_mode && hit && (rs < ls);
    eb_r = !slave_mode && hit && !(rs < ls);
  endtask

  task automatic update();
    bit lr, rr, lblk, rblk;
    logic [15:0] old_l, old_r;
    lr = lreq_f(); rr = rreq_f();
    lblk = slave_mode ? l_busy_i : eb_l;
    rblk = slave_mode ? r_busy_i : eb_r;
    old_l = m[l_addr]; old_r = m[r_addr];
    for (int b = 0; b < 2; b++) begin
      if (lr && !l_we && !eb_l && l_ben[b]) ml_q[b*8 +: 8] = old_l[b*8 +: 8];
      if (rr && !r_we && !eb_r && r_ben[b]) mr_q[b*8 +: 8] = old_r[b*8 +: 8];
    end
    for (int b = 0; b < 2; b++)
      if (lr && l_we && !lblk && l_ben[b]) m[l_addr][b*8 +: 8] = l_wdata[b*8 +: 8];
    for (int b = 0; b < 2; b++)
      if (rr && r_we && !rblk && r_ben[b]) m[r_addr][b*8 +: 8] = r_wdata[b*8 +: 8];
    lp_req = lr; rp_req = rr; lp_addr = l_addr; rp_addr = r_addr;
    lstart = ls; rstart = rs; cyc++;
  endtask

  task automatic tick(string tag);
    #1;
    eval_busy();
    chk(tag, "l_busy", {15'b0, l_busy_o}, {15'b0, eb_l});
    chk(tag, "r_busy", {15'b0, r_busy_o}, {15'b0, eb_r});
    @(posedge clk);
    update();
    @(negedge clk);
    chk(tag, "l_rdata", l_rdata, (l_cs && l_oe) ? ml_q : 16'h0);
    chk(tag, "r_rdata", r_rdata, (r_cs && r_oe) ? mr_q : 16'h0);
  endtask

  task automatic setl(logic cs, logic we, logic [1:0] ben, logic [AW-1:0] a, logic [15:0] d);
    l_cs = cs; l_we = we; l_oe = 1; l_ben = ben; l_addr = a; l_wdata = d;
  endtask
  task automatic setr(logic cs, logic we, logic [1:0] ben, logic [AW-1:0] a, logic [15:0] d);
    r_cs = cs; r_we = we; r_oe = 1; r_ben = ben; r_addr = a; r_wdata = d;
  endtask
  task automatic idle();
    setl(0, 0, 2'b11, 0, 0); setr(0, 0, 2'b11, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state visible with output enabled and no access
    setl(1, 0, 2'b00, 0, 0); setr(1, 0, 2'b00, 0, 0);
    #1;
    chk("R10", "l_rdata", l_rdata, 16'h0);
    chk("R10", "r_rdata", r_rdata, 16'h0);
    chk("R10", "busy", {14'b0, l_busy_o, r_busy_o}, 16'h0);
    @(negedge clk);
    rst_n = 1;

    // preload words used later
    for (int a = 0; a < 32; a++) begin
      setl(1, 1, 2'b11, AW'(a), 16'(16'h0100 + a)); setr(0, 0, 2'b11, 0, 0); tick("R1");
    end
    // R9 and R1: both ports write, extremes of the address range
    setl(1, 1, 2'b11, 0, 16'h1234); setr(1, 1, 2'b11, TOP, 16'hBEEF); tick("R9");
    setl(1, 0, 2'b11, TOP, 0); setr(1, 0, 2'b11, 0, 0); tick("R1");
    // R8: output enable low hides data, then shows held register
    l_oe = 0; r_oe = 0; tick("R8");
    setl(1, 0, 2'b00, 0, 0); setr(1, 0, 2'b00, 0, 0); tick("R8");
    // R2: lane writes and lane reads
    setl(1, 1, 2'b11, 5, 16'hAAAA); setr(0, 0, 2'b11, 0, 0); tick("R2");
    setl(1, 1, 2'b01, 5, 16'h1155); tick("R2");
    setl(1, 1, 2'b10, 5, 16'h7722); tick("R2");
    setl(1, 0, 2'b01, 5, 0); tick("R2");
    setl(1, 0, 2'b11, 5, 0); tick("R2");
    // R3: exclusion, chip select off, no lane
    setl(1, 1, 2'b11, 5, 16'hDEAD); l_excl = 1; tick("R3");
    l_excl = 0; setl(0, 1, 2'b11, 5, 16'hDEAD); tick("R3");
    setl(1, 1, 2'b00, 5, 16'hDEAD); tick("R3");
    setl(1, 0, 2'b11, 5, 0); tick("R3");
    // R5: same-cycle tie grants left; R6: right write dropped
    setl(1, 1, 2'b11, 9, 16'h9191); setr(1, 1, 2'b11, 9, 16'h6666); tick("R5");
    tick("R6");
    setl(0, 0, 2'b11, 0, 0); setr(1, 0, 2'b11, 9, 0); tick("R6");
    // R5: left earlier, right joins later and stays busy
    setl(1, 0, 2'b11, 9, 0); setr(1, 0, 2'b11, 3, 0); tick("R5");
    setr(1, 1, 2'b11, 9, 16'h5A5A); tick("R5");
    tick("R5");
    // R4: left leaves, right released and writes
    setl(0, 0, 2'b11, 9, 0); tick("R4");
    setr(1, 0, 2'b11, 9, 0); tick("R4");
    // R5: right earlier, left joins and loses; read of busy left not done
    setr(1, 0, 2'b11, 12, 0); setl(1, 0, 2'b11, 7, 0); tick("R5");
    setl(1, 0, 2'b11, 12, 0); tick("R6");
    setl(1, 1, 2'b11, 12, 16'hCCCC); tick("R6");
    setr(0, 0, 2'b11, 12, 0); tick("R4");
    // R4: different address ends contention
    setr(1, 0, 2'b11, 13, 0); tick("R4");
    // R7: master mode ignores busy inputs
    idle(); l_busy_i = 1; r_busy_i = 1;
    setl(1, 1, 2'b11, 14, 16'h1414); setr(1, 1, 2'b11, 15, 16'h1515); tick("R7");
    setl(1, 0, 2'b11, 14, 0); setr(1, 0, 2'b11, 15, 0); tick("R7");
    // R7: slave mode, busy input blocks write, release completes it
    slave_mode = 1; l_busy_i = 1; r_busy_i = 0;
    setl(1, 1, 2'b11, 20, 16'h2020); setr(1, 0, 2'b11, 20, 0); tick("R7");
    tick("R7");
    l_busy_i = 0; tick("R7");
    setl(0, 0, 2'b11, 0, 0); tick("R7");
    // R7: busy input does not block reads
    r_busy_i = 1; setr(1, 0, 2'b11, 14, 0); tick("R7");
    r_busy_i = 0;
    // R9: same-address write and read in one cycle returns old data
    setl(1, 1, 2'b11, 30, 16'h3030); setr(1, 0, 2'b11, 30, 0); tick("R9");
    setl(0, 0, 2'b11, 0, 0); tick("R9");
    slave_mode = 0;

    // mixed traffic on a few addresses, both modes
    for (int i = 0; i < 600; i++) begin
      if (i % 75 == 0) slave_mode = ~slave_mode;
      l_cs = ($urandom % 5) != 0; r_cs = ($urandom % 5) != 0;
      l_we = $urandom % 2; r_we = $urandom % 2;
      l_oe = ($urandom % 4) != 0; r_oe = ($urandom % 4) != 0;
      l_excl = ($urandom % 10) == 0; r_excl = ($urandom % 10) == 0;
      l_ben = 2'($urandom); r_ben = 2'($urandom);
      l_busy_i = ($urandom % 3) == 0; r_busy_i = ($urandom % 3) == 0;
      if (($urandom % 3) != 0) l_addr = ($urandom % 6 == 0) ? TOP : AW'($urandom % 4);
      if (($urandom % 3) != 0) r_addr = ($urandom % 6 == 0) ? TOP : AW'($urandom % 4);
      l_wdata = 16'($urandom); r_wdata = 16'($urandom);
      tick("R4");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule